// File: doc/BRIEF.md
# Split Multiply-Add-Accumulate Slice

This block is half of a DSP slice. It holds two 18x18 multipliers. The first stage combines their two products, by adding them or by subtracting one from the other. An optional register may follow that stage. After it comes a 44-bit second stage, which adds in a value from a neighbouring slice and can also add its own previous sum. An optional output stage follows. The result is also driven onto a chain-out bus, so that the next slice in a column can pick it up.

Signedness is set per operand port, not per operand. One select bit decides how both A operands are read, and a second bit decides how both B operands are read. Tying both selects low gives unsigned multiplication. Whether the first stage adds or subtracts is fixed by a parameter. Each register can be bypassed by a parameter, so latency can be traded against clock rate. The second stage takes nothing but the first-stage result, the chain input and its own held sum.

Top module: `mac_half_slice`

## Requirements
- R1: With `sgn_a`=0 both A operands are read as unsigned, and with `sgn_b`=0 both B operands are read as unsigned. When both selects are low, every product is non-negative.
- R2: With a select at 1, both operands of that port are read as two's complement. Signed and unsigned ports may be mixed. Each 36-bit product is sign-extended to 44 bits according to the signedness it actually has.
- R3: The first stage forms `a0*b0 + a1*b1` when the parameter SUBTRACT=0. It forms `a0*b0 - a1*b1` when SUBTRACT=1.
- R4: Latency from the operands to `result` is PIPE_EN + OUT_REG clock cycles. With both parameters at 0 the path is purely combinational.
- R5: Every cycle, `chain_in` is added to the first-stage result.
- R6: With `acc_en`=1 and `clr`=0, each enabled clock edge adds the first-stage result and `chain_in` to the held sum.
- R7: With `acc_en`=1 and `clr`=1, the held sum is dropped. The edge loads only the first-stage result plus `chain_in`.
- R8: With `ce`=0, every register in the slice holds its value, and the registered `result` does not change.
- R9: While `rst_n` is low, all registers are cleared, so `result` and `chain_out` read 0.
- R10: `chain_out` equals `result` in every cycle, with the same latency.
- R11: All second-stage sums wrap modulo 2^44.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable for all registers |
| sgn_a | input | 1 | 1 = A operands are two's complement |
| sgn_b | input | 1 | 1 = B operands are two's complement |
| a0 | input | OPW | First A operand |
| b0 | input | OPW | First B operand |
| a1 | input | OPW | Second A operand |
| b1 | input | OPW | Second B operand |
| chain_in | input | ACCW | Sum from the neighbouring slice |
| acc_en | input | 1 | Add the held sum into the second stage |
| clr | input | 1 | With acc_en, discard the held sum |
| result | output | ACCW | Slice result |
| chain_out | output | ACCW | Copy of result for the next slice |

## Verification
Two second-stage functions can happen in the same cycle: chained summation and accumulation. The bench drives a non-zero `chain_in` while `acc_en` is held high over several edges. It then compares `result` with (k+1) times the sum of the first-stage value and the chain value. A sum missing either term fails that comparison. A further case pushes the chained sum past 2^44 to show that it wraps.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;
   localparam int unsigned MAC_OPW_DEF  = 18;
   localparam int unsigned MAC_ACCW_DEF = 44;

   typedef enum logic {
      COMBINE_ADD = 1'b0,
      COMBINE_SUB = 1'b1
   } combine_e;
endpackage

// File: rtl/mac_operand_mult.sv
module mac_operand_mult #(
   parameter int unsigned OPW  = 18,
   parameter int unsigned ACCW = 44
) (
   input  logic [OPW-1:0]  a,
   input  logic [OPW-1:0]  b,
   input  logic            sa,
   input  logic            sb,
   output logic [ACCW-1:0] prod
);
   localparam int unsigned XW = OPW + 1;
   localparam int unsigned PW = 2 * XW;

   initial begin
      if (ACCW < PW) $error("ACCW too narrow for product");
   end

   logic signed [XW-1:0] ax, bx;
   logic signed [PW-1:0] pf;

   // one extra bit makes an unsigned operand a positive signed one
   assign ax = {sa & a[OPW-1], a};
   assign bx = {sb & b[OPW-1], b};
   assign pf = ax * bx;

   generate
      if (ACCW > PW) begin : g_ext
         assign prod = {{(ACCW-PW){pf[PW-1]}}, pf};
      end else begin : g_fit
         assign prod = pf;
      end
   endgenerate
endmodule

// File: rtl/mac_first_stage.sv
module mac_first_stage
   import mac_slice_pkg::*;
#(
   parameter int unsigned ACCW     = 44,
   parameter combine_e    COMBINE  = COMBINE_ADD,
   parameter bit          PIPE_EN  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ce,
   input  logic [ACCW-1:0] p0,
   input  logic [ACCW-1:0] p1,
   output logic [ACCW-1:0] s1_comb,
   output logic [ACCW-1:0] s1_out
);
   generate
      if (COMBINE == COMBINE_SUB) begin : g_sub
         assign s1_comb = p0 - p1;
      end else begin : g_add
         assign s1_comb = p0 + p1;
      end

      if (PIPE_EN) begin : g_pipe
         logic [ACCW-1:0] s1_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  s1_q <= '0;
            else if (ce) s1_q <= s1_comb;
         end
         assign s1_out = s1_q;
      end else begin : g_nopipe
         assign s1_out = s1_comb;
      end
   endgenerate
endmodule

// File: rtl/mac_second_stage.sv
module mac_second_stage #(
   parameter int unsigned ACCW    = 44,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ce,
   input  logic            acc_en,
   input  logic            clr,
   input  logic [ACCW-1:0] s1,
   input  logic [ACCW-1:0] chain_in,
   output logic [ACCW-1:0] acc_q,
   output logic [ACCW-1:0] result
);
   logic [ACCW-1:0] fb;
   logic [ACCW-1:0] sum;

   assign fb  = (acc_en && !clr) ? acc_q : '0;
   assign sum = s1 + chain_in + fb;

   // held sum is always registered so the feedback path never closes combinationally
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc_q <= '0;
      else if (ce) acc_q <= sum;
   end

   generate
      if (OUT_REG) begin : g_reg
         assign result = acc_q;
      end else begin : g_comb
         assign result = sum;
      end
   endgenerate
endmodule

// File: rtl/mac_half_slice.sv
module mac_half_slice
   import mac_slice_pkg::*;
#(
   parameter int unsigned OPW      = MAC_OPW_DEF,
   parameter int unsigned ACCW     = MAC_ACCW_DEF,
   parameter combine_e    COMBINE  = COMBINE_ADD,
   parameter bit          PIPE_EN  = 1'b1,
   parameter bit          OUT_REG  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ce,
   input  logic            sgn_a,
   input  logic            sgn_b,
   input  logic [OPW-1:0]  a0,
   input  logic [OPW-1:0]  b0,
   input  logic [OPW-1:0]  a1,
   input  logic [OPW-1:0]  b1,
   input  logic [ACCW-1:0] chain_in,
   input  logic            acc_en,
   input  logic            clr,
   output logic [ACCW-1:0] result,
   output logic [ACCW-1:0] chain_out
);
   localparam int unsigned NMUL = 2;

   initial begin
      if (OPW < 2)           $error("OPW must be at least 2");
      if (ACCW < 2*OPW + 2)  $error("ACCW must hold a full product");
   end

   logic [OPW-1:0]  op_a [NMUL];
   logic [OPW-1:0]  op_b [NMUL];
   logic [ACCW-1:0] prod [NMUL];
   logic [ACCW-1:0] s1_comb;
   logic [ACCW-1:0] s1_feed;
   logic [ACCW-1:0] acc_q;

   assign op_a[0] = a0;
   assign op_a[1] = a1;
   assign op_b[0] = b0;
   assign op_b[1] = b1;

   // sign selects are shared across each port
   generate
      for (genvar g = 0; g < NMUL; g++) begin : g_mul
         mac_operand_mult #(.OPW(OPW), .ACCW(ACCW)) u_mult (
            .a(op_a[g]), .b(op_b[g]), .sa(sgn_a), .sb(sgn_b), .prod(prod[g])
         );
      end
   endgenerate

   mac_first_stage #(.ACCW(ACCW), .COMBINE(COMBINE), .PIPE_EN(PIPE_EN)) u_s1 (
      .clk(clk), .rst_n(rst_n), .ce(ce),
      .p0(prod[0]), .p1(prod[1]),
      .s1_comb(s1_comb), .s1_out(s1_feed)
   );

   mac_second_stage #(.ACCW(ACCW), .OUT_REG(OUT_REG)) u_s2 (
      .clk(clk), .rst_n(rst_n), .ce(ce), .acc_en(acc_en), .clr(clr),
      .s1(s1_feed), .chain_in(chain_in), .acc_q(acc_q), .result(result)
   );

   assign chain_out = result;
endmodule

// File: rtl/mac_half_slice_chk.sv
module mac_half_slice_chk #(
   parameter int unsigned OPW  = 18,
   parameter int unsigned ACCW = 44
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ce,
   input logic            acc_en,
   input logic            clr,
   input logic            sgn_a,
   input logic            sgn_b,
   input logic [OPW-1:0]  a0,
   input logic [ACCW-1:0] prod0,
   input logic [ACCW-1:0] s1_feed,
   input logic [ACCW-1:0] chain_in,
   input logic [ACCW-1:0] acc_q
);
   a_r1_unsigned_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
      (!sgn_a && !sgn_b) |-> !prod0[ACCW-1]);

   a_r2_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
      (a0 == '0) |-> (prod0 == '0));

   a_r6_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && acc_en && !clr) |=> (acc_q == $past(acc_q + s1_feed + chain_in)));

   a_r7_clear_load: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && acc_en && clr) |=> (acc_q == $past(s1_feed + chain_in)));

   a_r8_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce) |=> $stable(acc_q));
endmodule

bind mac_half_slice mac_half_slice_chk #(.OPW(OPW), .ACCW(ACCW)) u_chk (
   .clk(clk), .rst_n(rst_n), .ce(ce), .acc_en(acc_en), .clr(clr),
   .sgn_a(sgn_a), .sgn_b(sgn_b), .a0(a0), .prod0(prod[0]),
   .s1_feed(s1_feed), .chain_in(chain_in), .acc_q(acc_q)
);

// File: tb/test_mac_half_slice.sv
`timescale 1ns/1ps
module test_mac_half_slice;
   import mac_slice_pkg::*;
   localparam int W = 18;
   localparam int AW = 44;

   logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0;
   logic sgn_a = 1'b0, sgn_b = 1'b0, acc_en = 1'b0, clr = 1'b0;
   logic [W-1:0] a0 = '0, b0 = '0, a1 = '0, b1 = '0;
   logic [AW-1:0] chain_in = '0;
   logic [AW-1:0] result, chain_out, result_s, chain_out_s;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   mac_half_slice i_mac_half_slice (
      .clk(clk), .rst_n(rst_n), .ce(ce), .sgn_a(sgn_a), .sgn_b(sgn_b),
      .a0(a0), .b0(b0), .a1(a1), .b1(b1), .chain_in(chain_in),
      .acc_en(acc_en), .clr(clr), .result(result), .chain_out(chain_out));

   mac_half_slice #(.COMBINE(COMBINE_SUB), .PIPE_EN(1'b0), .OUT_REG(1'b0)) i_mac_half_slice_sub (
      .clk(clk), .rst_n(rst_n), .ce(ce), .sgn_a(sgn_a), .sgn_b(sgn_b),
      .a0(a0), .b0(b0), .a1(a1), .b1(b1), .chain_in(chain_in),
      .acc_en(1'b0), .clr(1'b0), .result(result_s), .chain_out(chain_out_s));

   function automatic longint val(logic [W-1:0] x, logic s);
      longint v = longint'(x);
      if (s && x[W-1]) v = v - (longint'(1) << W);
      return v;
   endfunction

   function automatic logic [AW-1:0] mp(logic [W-1:0] a, logic [W-1:0] b, logic sa, logic sb);
      longint p = val(a, sa) * val(b, sb);
      return p[AW-1:0];
   endfunction

   task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_ops(logic [W-1:0] x0, logic [W-1:0] y0, logic [W-1:0] x1, logic [W-1:0] y1,
                          logic sa, logic sb);
      a0 = x0; b0 = y0; a1 = x1; b1 = y1; sgn_a = sa; sgn_b = sb;
   endtask

   task automatic t_reset;
      check("R9 reset result", result, '0);
      check("R9 reset chain_out", chain_out, '0);
   endtask

   task automatic t_unsigned;
      logic [AW-1:0] e;
      set_ops(18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h00002, 1'b0, 1'b0);
      e = mp(18'h3FFFF, 18'h3FFFF, 0, 0) + mp(18'h3FFFF, 18'h00002, 0, 0);
      step(2);
      check("R1 unsigned sum", result, e);
      check("R10 chain_out mirror", chain_out, result);
   endtask

   task automatic t_signed;
      logic [AW-1:0] e;
      set_ops(18'h3FFFF, 18'h3FFFE, 18'h3FFFF, 18'h00005, 1'b1, 1'b1);
      e = 44'(longint'(2 - 5));
      step(2);
      check("R2 both signed", result, e);
      set_ops(18'h3FFFF, 18'h3FFFF, 18'h00000, 18'h00000, 1'b1, 1'b0);
      e = 44'(-longint'(262143));
      step(2);
      check("R2 mixed signed A unsigned B", result, e);
      check("R2 mixed sub instance", result_s, e);
   endtask

   task automatic t_sub_and_latency;
      set_ops(18'd10, 18'd10, 18'd3, 18'd7, 1'b0, 1'b0);
      step(2);
      check("R3 add mode", result, 44'd121);
      #1 check("R3 subtract mode", result_s, 44'd79);
      set_ops(18'd20, 18'd20, 18'd1, 18'd1, 1'b0, 1'b0);
      #1 check("R4 bypass immediate", result_s, 44'd399);
      step(1);
      check("R4 one edge old value", result, 44'd121);
      step(1);
      check("R4 two edges new value", result, 44'd401);
   endtask

   task automatic t_chain;
      chain_in = 44'h0123456789A;
      step(1);
      #1 check("R5 chain sub instance", result_s, 44'h0123456789A + 44'd399);
      step(1);
      check("R5 chain added", result, 44'h0123456789A + 44'd401);
      chain_in = '0;
      step(1);
   endtask

   task automatic t_accum;
      set_ops(18'd100, 18'd3, 18'd0, 18'd0, 1'b0, 1'b0);
      step(2);
      acc_en = 1'b1;
      step(3);
      check("R6 accumulate x4", result, 44'd1200);
      clr = 1'b1;
      step(1);
      check("R7 clear loads fresh", result, 44'd300);
      clr = 1'b0;
      step(1);
      check("R6 accumulate after clear", result, 44'd600);
   endtask

   task automatic t_both;
      chain_in = 44'd7;
      clr = 1'b1;
      step(1);
      check("R7 clear with chain", result, 44'd307);
      clr = 1'b0;
      step(3);
      check("R5 R6 chain and accumulate same cycle", result, 44'd1228);
   endtask

   task automatic t_ce;
      ce = 1'b0;
      set_ops(18'd9, 18'd9, 18'd9, 18'd9, 1'b0, 1'b0);
      chain_in = 44'd55;
      step(3);
      check("R8 ce low holds", result, 44'd1228);
      ce = 1'b1;
      acc_en = 1'b0;
      step(2);
      check("R8 ce restored", result, 44'd162 + 44'd55);
   endtask

   task automatic t_wrap;
      set_ops(18'd1, 18'd2, 18'd0, 18'd0, 1'b0, 1'b0);
      chain_in = {AW{1'b1}};
      step(2);
      check("R11 wrap modulo", result, 44'd1);
      check("R10 chain_out on wrap", chain_out, 44'd1);
      chain_in = '0;
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      step(2);
      t_reset();
      rst_n = 1'b1;
      ce = 1'b1;
      step(1);
      t_unsigned();
      t_signed();
      t_sub_and_latency();
      t_chain();
      t_accum();
      t_both();
      t_ce();
      t_wrap();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule